// File: doc/BRIEF.md
# Syntonized Schedule Delta Timebase

This block generates the delta strobe that paces a gate-control scheduler. It runs on the scheduler tick clock. That oscillator also drives a PTP time-of-day counter, and a software servo may rate-correct the counter. Nominally a delta is 25 ticks (200 ns). Because the PTP counter can run slightly fast or slow against the ticks, a fixed 25-tick delta would slowly drift away from PTP time. The block measures that drift over a correction period. It then lengthens or shortens later deltas by whole ticks, so that over time the delta stream tracks 25 PTP units per delta.

Software programs a schedule start time and a correction-period length (both in PTP units), then raises `enable`. The block arms. When PTP time first reaches the start time, it issues a one-cycle start pulse together with the first delta strobe. From then on it runs free. The controller has three states:
- `ST_IDLE`: disabled.
- `ST_ARM`: waiting for the start time.
- `ST_RUN`: producing deltas.

The named transitions are:
- IDLE→ARM when `enable` is high.
- ARM→RUN (the launch) when `ptp_time >= sched_start`.
- ARM→IDLE and RUN→IDLE when `enable` drops.
- RUN stays in RUN otherwise.

Top module: `sdt_timebase`

## Requirements
- R1: At every clock edge that samples `enable` low, both outputs go low after that edge. The signed drift accumulator and the correction-period tick counter are cleared at that edge. A later session therefore starts with plain 25-tick deltas, whatever correction was left over.
- R2: The first edge with `enable` high enters ST_ARM. At the first later edge where `ptp_time >= sched_start`, the block launches: `start_pulse` and `delta_strobe` are both high for the one cycle after that edge. With PTP advancing one unit per tick and the start time L units ahead, launch happens L+1 edges after `enable` rises.
- R3: With PTP advancing exactly one unit per tick, consecutive `delta_strobe` pulses are exactly 25 cycles apart.
- R4: A correction period begins at the launch edge, recording that edge's PTP value. Its boundary is the first later edge where the PTP time elapsed since the period start is at least `corr_period`. At the boundary, the drift (ticks elapsed since the period start minus PTP units elapsed) is added to a signed accumulator, and a new period starts from that edge's PTP value.
- R5: A delta begun at a strobe edge lasts 25 + clamp(acc, -5, +5) cycles. Here acc is the accumulator value before any boundary update at the same edge. The amount applied is subtracted from the accumulator. Every strobe spacing therefore lies between 20 and 30 cycles.
- R6: For a PTP clock that is 10% fast or 10% slow, or 4% fast, against the ticks, the PTP time spanned by 160 consecutive deltas after the first 40 equals 160 × 25 to within 160 units (one tick per delta on average).
- R7: `start_pulse` fires exactly once per enable session.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scheduler tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Arms and runs the timebase; low clears it |
| ptp_time | input | PTP_W (48) | Current PTP time in tick-sized units |
| sched_start | input | PTP_W (48) | PTP time at which the schedule engine starts |
| corr_period | input | PER_W (16) | Correction-period length in PTP units |
| delta_strobe | output | 1 | One-cycle pulse at the start of each delta |
| start_pulse | output | 1 | One-cycle pulse when the schedule engine starts |

## Verification
The bench checks several cases against spacings it computes by hand:
- A single pause in PTP gives a boundary drift of +12, which must appear as the exact spacing run 30, 30, 27. A design that took the slew from the post-update accumulator, or that ignored it, would shift or drop that pattern.
- A burst of double PTP steps gives a drift of -8, which must appear as 20, 22. A design with the drift sign inverted would stretch these deltas instead.
- A disable taken just after a boundary, before any correction is spent, must leave the next session at plain 25-tick deltas. A design that kept the accumulator across sessions would repeat the stretch.
- Sustained rate offsets of ±10% and +4% must keep the PTP span of 160 deltas near 4000. An uncorrected or saturating design would miss that span by hundreds of units.

// File: rtl/sdt_pkg.sv
package sdt_pkg;

    // Controller states of the delta timebase
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // disabled, everything held clear
        ST_ARM  = 2'd1,   // waiting for PTP time to reach the start time
        ST_RUN  = 2'd2    // producing deltas
    } sdt_state_e;

endpackage

// File: rtl/sdt_period_meter.sv
// Measures tick-versus-PTP drift over each correction period.
module sdt_period_meter #(
    parameter int PTP_W = 48,
    parameter int PER_W = 16,
    parameter int ACC_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    launch,
    input  logic                    run,
    input  logic [PTP_W-1:0]        ptp_time,
    input  logic [PER_W-1:0]        corr_period,
    output logic                    bound,
    output logic signed [ACC_W-1:0] drift
);
    localparam int CNT_W = PER_W + 2;

    logic [PTP_W-1:0] per_start_q;
    logic [CNT_W-1:0] tick_cnt_q;
    logic [PTP_W-1:0] elapsed;
    logic [CNT_W-1:0] ticks_now;

    assign elapsed   = ptp_time - per_start_q;
    assign ticks_now = tick_cnt_q + CNT_W'(1);
    assign bound     = run && (elapsed >= PTP_W'(corr_period));
    // positive drift: more ticks than PTP units, so deltas must lengthen
    assign drift     = $signed(ACC_W'(ticks_now)) - $signed(ACC_W'(elapsed));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_start_q <= '0;
            tick_cnt_q  <= '0;
        end else if (clear) begin
            per_start_q <= '0;
            tick_cnt_q  <= '0;
        end else if (launch) begin
            per_start_q <= ptp_time;
            tick_cnt_q  <= '0;
        end else if (run) begin
            if (bound) begin
                per_start_q <= ptp_time;
                tick_cnt_q  <= '0;
            end else begin
                tick_cnt_q  <= ticks_now;
            end
        end
    end

    AST_PERIOD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        bound |=> (tick_cnt_q == '0)); // R4

    AST_CLEARED_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (tick_cnt_q == '0 && per_start_q == '0)); // R1

endmodule

// File: rtl/sdt_delta_pacer.sv
// Issues delta strobes and spends the drift accumulator under a slew limit.
module sdt_delta_pacer #(
    parameter int NOM_TICKS  = 25,
    parameter int SLEW_TICKS = 5,
    parameter int ACC_W      = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    launch,
    input  logic                    run,
    input  logic                    bound,
    input  logic signed [ACC_W-1:0] drift,
    output logic                    strobe
);
    localparam int LEN_W = $clog2(NOM_TICKS + SLEW_TICKS + 1);
    localparam logic signed [ACC_W-1:0] SLEW_S = ACC_W'(SLEW_TICKS);
    localparam logic signed [ACC_W-1:0] NOM_S  = ACC_W'(NOM_TICKS);
    localparam logic signed [ACC_W-1:0] HEAD_S = ACC_W'(1) <<< (ACC_W - 2);

    logic signed [ACC_W-1:0] acc_q, acc_d, step, add_term, sub_term, len_s;
    logic [LEN_W-1:0]        cnt_q, len_q;
    logic                    delta_end, take;

    // slew limit: at most SLEW_TICKS of correction in one delta
    always_comb begin
        if (acc_q > SLEW_S) begin
            step = SLEW_S;
        end else if (acc_q < -SLEW_S) begin
            step = -SLEW_S;
        end else begin
            step = acc_q;
        end
    end

    assign len_s     = NOM_S + step;
    assign delta_end = run && (cnt_q == len_q - LEN_W'(1));
    assign take      = launch || delta_end;
    assign add_term  = bound ? drift : '0;
    assign sub_term  = take ? step : '0;
    assign acc_d     = acc_q + add_term - sub_term;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= '0;
            cnt_q  <= '0;
            len_q  <= LEN_W'(NOM_TICKS);
            strobe <= 1'b0;
        end else if (clear) begin
            acc_q  <= '0;
            cnt_q  <= '0;
            len_q  <= LEN_W'(NOM_TICKS);
            strobe <= 1'b0;
        end else begin
            strobe <= take;
            if (take) begin
                cnt_q <= '0;
                len_q <= LEN_W'(len_s);
            end else if (run) begin
                cnt_q <= cnt_q + LEN_W'(1);
            end
            if (take || run) begin
                acc_q <= acc_d;
            end
        end
    end

    AST_ACC_HEADROOM: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_q < HEAD_S) && (acc_q > -HEAD_S)); // R4

    AST_CLEAR_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (acc_q == '0 && !strobe)); // R1

endmodule

// File: rtl/sdt_timebase.sv
// Top: start-time controller plus drift meter and delta pacer.
module sdt_timebase
    import sdt_pkg::*;
#(
    parameter int PTP_W      = 48,
    parameter int PER_W      = 16,
    parameter int NOM_TICKS  = 25,
    parameter int SLEW_TICKS = 5,
    parameter int ACC_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [PTP_W-1:0] ptp_time,
    input  logic [PTP_W-1:0] sched_start,
    input  logic [PER_W-1:0] corr_period,
    output logic             delta_strobe,
    output logic             start_pulse
);
    localparam int GAP_W = $clog2(NOM_TICKS + SLEW_TICKS + 2) + 1;

    sdt_state_e              state_q, state_d;
    logic                    launch, run, clear, bound;
    logic signed [ACC_W-1:0] drift;

    assign clear  = !enable;
    assign launch = (state_q == ST_ARM) && enable && (ptp_time >= sched_start);
    assign run    = (state_q == ST_RUN) && enable;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (enable) state_d = ST_ARM;
            ST_ARM: begin
                if (!enable) begin
                    state_d = ST_IDLE;
                end else if (ptp_time >= sched_start) begin
                    state_d = ST_RUN;
                end
            end
            ST_RUN:  if (!enable) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_pulse <= 1'b0;
        end else begin
            start_pulse <= launch;
        end
    end

    sdt_period_meter #(
        .PTP_W (PTP_W),
        .PER_W (PER_W),
        .ACC_W (ACC_W)
    ) u_meter (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (clear),
        .launch      (launch),
        .run         (run),
        .ptp_time    (ptp_time),
        .corr_period (corr_period),
        .bound       (bound),
        .drift       (drift)
    );

    sdt_delta_pacer #(
        .NOM_TICKS  (NOM_TICKS),
        .SLEW_TICKS (SLEW_TICKS),
        .ACC_W      (ACC_W)
    ) u_pacer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (clear),
        .launch (launch),
        .run    (run),
        .bound  (bound),
        .drift  (drift),
        .strobe (delta_strobe)
    );

    // spacing observer for the strobe-gap assertion
    logic [GAP_W-1:0] gap_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (!enable) begin
            gap_q <= '0;
        end else if (delta_strobe) begin
            gap_q <= GAP_W'(1);
        end else if (gap_q != '0 && gap_q != '1) begin
            gap_q <= gap_q + GAP_W'(1);
        end
    end

    AST_GAP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (delta_strobe && !start_pulse && gap_q != '0) |->
        (gap_q >= GAP_W'(NOM_TICKS - SLEW_TICKS) && gap_q <= GAP_W'(NOM_TICKS + SLEW_TICKS))); // R5

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse); // R2

    AST_START_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> delta_strobe); // R2

    AST_START_AT_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> $past(ptp_time >= sched_start)); // R2

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!delta_strobe && !start_pulse)); // R1

    AST_SINGLE_START: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_RUN && state_q == ST_RUN) |-> !start_pulse); // R7

endmodule

// File: tb/sdt_timebase_tb.sv
module sdt_timebase_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NOM  = 25;
    localparam int SLEW = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [47:0] ptp_time = 48'd1000;
    logic [47:0] sched_start = '0;
    logic [15:0] corr_period = 16'd500;
    logic        delta_strobe, start_pulse;

    sdt_timebase u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .ptp_time     (ptp_time),
        .sched_start  (sched_start),
        .corr_period  (corr_period),
        .delta_strobe (delta_strobe),
        .start_pulse  (start_pulse)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int     n_chk = 0, n_bad = 0;
    bit     done = 0;
    // PTP rate model
    int     rate_div = 0, rate_inc = 1, rate_ph = 0, pause_left = 0, jump_left = 0;
    // observation state
    int     mst = 0, ngap = 0, n_starts = 0;
    bit     saw_start = 0;
    longint cyc = 0, last_cyc = 0;
    int     gaps [0:255];
    longint sptp [0:255];

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // one clock: sample outputs at the falling edge, then advance PTP time
    task automatic tick();
        bit exp_start;
        int inc;
        @(negedge clk);
        cyc++;
        exp_start = 0;
        if (!rst_n || !enable) begin
            mst = 0;
        end else if (mst == 0) begin
            mst = 1;
        end else if (mst == 1 && ptp_time >= sched_start) begin
            mst = 2;
            exp_start = 1;
        end
        if (!rst_n || !enable) begin
            check(!delta_strobe && !start_pulse, "R1", "outputs while disabled",
                  {delta_strobe, start_pulse}, 0);
        end else if (exp_start || start_pulse) begin
            check(start_pulse == exp_start, "R2", "start pulse timing", start_pulse, exp_start);
            check(delta_strobe == 1'b1, "R2", "strobe with start", delta_strobe, 1);
        end
        if (start_pulse) begin
            saw_start = 1;
            n_starts++;
        end
        if (delta_strobe && rst_n && enable) begin
            if (exp_start) begin
                ngap = 0;
                sptp[0] = longint'(ptp_time);
            end else begin
                ngap++;
                check((cyc - last_cyc) >= NOM - SLEW && (cyc - last_cyc) <= NOM + SLEW,
                      "R5", "strobe spacing range", cyc - last_cyc, NOM);
                if (ngap < 256) begin
                    gaps[ngap] = int'(cyc - last_cyc);
                    sptp[ngap] = longint'(ptp_time);
                end
            end
            last_cyc = cyc;
        end
        inc = 1;
        if (pause_left > 0) begin
            inc = 0;
            pause_left--;
        end else if (jump_left > 0) begin
            inc = 2;
            jump_left--;
        end else if (rate_div > 0) begin
            rate_ph++;
            if (rate_ph == rate_div) begin
                rate_ph = 0;
                inc = rate_inc;
            end
        end
        ptp_time = ptp_time + 48'(inc);
    endtask

    task automatic run_ticks(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic arm(int lead, int period);
        corr_period = 16'(period);
        sched_start = ptp_time + 48'(lead);
        n_starts = 0;
        enable = 1'b1;
    endtask

    task automatic wait_start(output int waited);
        waited = 0;
        saw_start = 0;
        while (!saw_start && waited < 3000) begin
            tick();
            waited++;
        end
    endtask

    task automatic disarm();
        enable = 1'b0;
        rate_div = 0;
        pause_left = 0;
        jump_left = 0;
        run_ticks(10);
    endtask

    task automatic check_gaps(string req, int from, int to, int expv);
        for (int k = from; k <= to; k++) begin
            check(gaps[k] == expv, req, $sformatf("spacing %0d", k), gaps[k], expv);
        end
    endtask

    task automatic rate_run(int div, int inc, string tag);
        int w;
        int guard;
        longint span;
        rate_div = div;
        rate_inc = inc;
        rate_ph = 0;
        arm(20, 500);
        wait_start(w);
        guard = 0;
        while (ngap < 200 && guard < 8000) begin
            tick();
            guard++;
        end
        span = sptp[200] - sptp[40];
        check(span >= 4000 - 160 && span <= 4000 + 160, "R6",
              {"PTP span of 160 deltas ", tag}, span, 4000);
        disarm();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R6 watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int w;
        // reset state
        run_ticks(3);
        check(!delta_strobe && !start_pulse, "R1", "outputs in reset", {delta_strobe, start_pulse}, 0);
        rst_n = 1'b1;
        run_ticks(20);

        // nominal rate, launch timing, single start
        arm(40, 500);
        wait_start(w);
        check(w == 41, "R2", "edges from enable to launch", w, 41);
        run_ticks(300);
        check_gaps("R3", 1, 11, NOM);
        check(n_starts == 1, "R7", "start pulses in session", n_starts, 1);
        disarm();

        // positive drift +12 from a PTP pause: spacings 30,30,27
        arm(30, 200);
        wait_start(w);
        run_ticks(50);
        pause_left = 12;
        run_ticks(500);
        check_gaps("R4", 1, 9, NOM);
        check(gaps[10] == 30, "R5", "first stretched delta", gaps[10], 30);
        check(gaps[11] == 30, "R5", "second stretched delta", gaps[11], 30);
        check(gaps[12] == 27, "R5", "remainder delta", gaps[12], 27);
        check_gaps("R4", 13, 19, NOM);
        disarm();

        // negative drift -8 from doubled PTP steps: spacings 20,22
        arm(30, 200);
        wait_start(w);
        run_ticks(50);
        jump_left = 8;
        run_ticks(400);
        check_gaps("R4", 1, 8, NOM);
        check(gaps[9] == 20, "R5", "first shortened delta", gaps[9], 20);
        check(gaps[10] == 22, "R5", "remainder shortened delta", gaps[10], 22);
        check_gaps("R4", 11, 15, NOM);
        disarm();

        // disable right after a boundary leaves correction unspent; next session nominal
        arm(30, 200);
        wait_start(w);
        run_ticks(50);
        pause_left = 12;
        run_ticks(165);
        disarm();
        arm(20, 500);
        wait_start(w);
        run_ticks(280);
        check_gaps("R1", 1, 10, NOM);
        disarm();

        // sustained rate offsets
        rate_run(10, 2, "10% fast");
        rate_run(10, 0, "10% slow");
        rate_run(25, 2, "4% fast");

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule